// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Word

This block keeps the exception bookkeeping for a floating-point coprocessor. The execution datapath reports each fault as a one-cycle pulse on one of seven lines. The block turns each pulse into a sticky flag and packs the flags into a 16-bit status word. That word also carries a summary bit, a live busy bit, four condition-code bits and the three-bit stack-top pointer. Software reads the whole status word in one go, and a dedicated command wipes the flags.

A 16-bit control word sits beside the status word. It is loaded whole and holds one mask bit for each of the six maskable faults, plus a rounding field and a precision field that drive the arithmetic. An interrupt request is raised while any flagged fault has its mask bit clear. The interrupt path can be built combinational or registered through a parameter.

Top module: `fpu_exc_status`

## Requirements
- R1: After reset the control word reads 0x037F, all seven exception flags and the summary bit are 0, and irq is low.
- R2: A pulse on exc_pulse[k] sets status bit k at the next clock edge, with invalid=bit0, denormal=bit1, zero-divide=bit2, overflow=bit3, underflow=bit4, precision=bit5 and stack fault=bit6.
- R3: Exception flags are sticky: once set, a flag stays set through any cycles without a clear command.
- R4: clr_exc zeroes all seven flags at the next edge; a pulse arriving in the same cycle as the clear is kept, so its flag is set after that edge.
- R5: Status bit 7 is the OR of status bits 6:0.
- R6: irq is high exactly while some status bit k in 5:0 is 1 with control bit k equal to 0; the stack-fault flag alone never raises irq.
- R7: cw_load stores all 16 bits of cw_data into the control word at the next edge; without cw_load the control word holds its value.
- R8: round_ctl equals control bits 11:10 (00 nearest, 01 down, 10 up, 11 toward zero) and prec_ctl equals control bits 9:8 (00 single, 10 double, 11 extended).
- R9: Status bits 15:8 reflect the inputs in the same cycle: busy_in at bit 15, cc_in[3] at bit 14, top_in at bits 13:11, and cc_in[2:0] at bits 10:8.
- R10: Changing a mask bit alters irq from the cycle after the load, and the flag itself is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_pulse | input | 7 | One-cycle exception reports, bit order as in R2 |
| clr_exc | input | 1 | Clear all exception flags |
| cw_load | input | 1 | Load control word from cw_data |
| cw_data | input | 16 | New control word value |
| busy_in | input | 1 | Execution busy indication |
| cc_in | input | 4 | Condition codes C3..C0 |
| top_in | input | 3 | Register stack top pointer |
| sw_out | output | 16 | Packed status word |
| cw_out | output | 16 | Current control word |
| irq | output | 1 | Unmasked exception interrupt request |
| round_ctl | output | 2 | Rounding mode |
| prec_ctl | output | 2 | Precision selection |

## Verification
Three events can land in the same cycle: a clear, a fresh fault pulse and a control-word load. These are the hardest to line up from the ports, because each one changes what the next cycle's irq should be. The vector table drives all three within single steps. A clear coincides with a new overflow pulse. A zero-divide pulse arrives together with a load that unmasks everything. A later load re-masks some flags that are still set. After each step, the flags, irq and control word are compared with values worked out from the requirements.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
   localparam int unsigned WORD_W   = 16;
   localparam int unsigned MASKED_N = 6;
   localparam int unsigned FLAG_N   = MASKED_N + 1;

   typedef struct packed {
      logic       busy;
      logic       c3;
      logic [2:0] top;
      logic       c2;
      logic       c1;
      logic       c0;
      logic       summary;
      logic       stack_fault;
      logic [MASKED_N-1:0] exc;
   } status_t;

   typedef struct packed {
      logic [3:0] spare_hi;
      logic [1:0] rnd;
      logic [1:0] prec;
      logic [1:0] spare_lo;
      logic [MASKED_N-1:0] mask;
   } control_t;
endpackage

// File: rtl/fxs_flag_bank.sv
module fxs_flag_bank #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flags_o
);
   if (N < 1) begin : g_bad_n
      $error("fxs_flag_bank: N must be at least 1");
   end

   for (genvar k = 0; k < N; k++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= (flag_q & ~clr_i) | set_i[k];
      end
      assign flags_o[k] = flag_q;
   end
endmodule

// File: rtl/fxs_ctl_reg.sv
module fxs_ctl_reg #(
   parameter int unsigned      W     = 16,
   parameter logic [W-1:0]     RESET = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] word_o
);
   logic [W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= RESET;
      else if (load_i) word_q <= data_i;
   end

   assign word_o = word_q;
endmodule

// File: rtl/fxs_irq_gate.sv
module fxs_irq_gate #(
   parameter int unsigned N          = 6,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o
);
   logic pending;
   assign pending = |(flags_i & ~mask_i);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = pending;
   end
endmodule

// File: rtl/fpu_exc_status.sv
module fpu_exc_status
   import fxs_pkg::*;
#(
   parameter int unsigned       NUM_MASKED     = 6,
   parameter logic [15:0]       CW_RESET       = 16'h037F,
   parameter bit                IRQ_REGISTERED = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [6:0]  exc_pulse,
   input  logic        clr_exc,
   input  logic        cw_load,
   input  logic [15:0] cw_data,
   input  logic        busy_in,
   input  logic [3:0]  cc_in,
   input  logic [2:0]  top_in,
   output logic [15:0] sw_out,
   output logic [15:0] cw_out,
   output logic        irq,
   output logic [1:0]  round_ctl,
   output logic [1:0]  prec_ctl
);
   localparam int unsigned NFLAG = NUM_MASKED + 1;

   if (NUM_MASKED != MASKED_N) begin : g_bad_masked
      $error("fpu_exc_status: status layout fixes NUM_MASKED at 6");
   end
   if (NFLAG != FLAG_N) begin : g_bad_flag
      $error("fpu_exc_status: flag count mismatch");
   end

   logic [NFLAG-1:0] flags;
   status_t          sw;
   control_t         cw;

   fxs_flag_bank #(.N(NFLAG)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (exc_pulse),
      .clr_i   (clr_exc),
      .flags_o (flags)
   );

   fxs_ctl_reg #(.W(WORD_W), .RESET(CW_RESET)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cw_load),
      .data_i (cw_data),
      .word_o (cw)
   );

   fxs_irq_gate #(.N(NUM_MASKED), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags[NUM_MASKED-1:0]),
      .mask_i  (cw.mask),
      .irq_o   (irq)
   );

   always_comb begin
      sw.busy        = busy_in;
      sw.c3          = cc_in[3];
      sw.top         = top_in;
      sw.c2          = cc_in[2];
      sw.c1          = cc_in[1];
      sw.c0          = cc_in[0];
      sw.summary     = |flags;
      sw.stack_fault = flags[NFLAG-1];
      sw.exc         = flags[NUM_MASKED-1:0];
   end

   assign sw_out    = sw;
   assign cw_out    = cw;
   assign round_ctl = cw.rnd;
   assign prec_ctl  = cw.prec;
endmodule

// File: rtl/fpu_exc_status_chk.sv
module fpu_exc_status_chk #(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic [6:0]  exc_pulse,
   input logic        clr_exc,
   input logic        cw_load,
   input logic [15:0] cw_data,
   input logic        busy_in,
   input logic [3:0]  cc_in,
   input logic [2:0]  top_in,
   input logic [15:0] sw_out,
   input logic [15:0] cw_out,
   input logic        irq,
   input logic [1:0]  round_ctl,
   input logic [1:0]  prec_ctl
);
   assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_pulse != 7'd0) |=> ((sw_out[6:0] & $past(exc_pulse)) == $past(exc_pulse)));

   assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_exc |=> ((sw_out[6:0] & $past(sw_out[6:0])) == $past(sw_out[6:0])));

   assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_exc && exc_pulse == 7'd0) |=> (sw_out[6:0] == 7'd0));

   assert_summary_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_out[7] == (|sw_out[6:0]));

   if (!IRQ_REGISTERED) begin : g_irq_chk
      assert_irq_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq == (|(sw_out[5:0] & ~cw_out[5:0])));
   end

   assert_cw_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cw_load |=> (cw_out == $past(cw_data)));

   assert_cw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cw_load |=> $stable(cw_out));

   assert_mode_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (round_ctl == cw_out[11:10]) && (prec_ctl == cw_out[9:8]));

   assert_live_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_out[15:8] == {busy_in, cc_in[3], top_in, cc_in[2:0]});
endmodule

bind fpu_exc_status fpu_exc_status_chk #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exc_pulse (exc_pulse),
   .clr_exc   (clr_exc),
   .cw_load   (cw_load),
   .cw_data   (cw_data),
   .busy_in   (busy_in),
   .cc_in     (cc_in),
   .top_in    (top_in),
   .sw_out    (sw_out),
   .cw_out    (cw_out),
   .irq       (irq),
   .round_ctl (round_ctl),
   .prec_ctl  (prec_ctl)
);

// File: tb/test_fpu_exc_status.sv
module test_fpu_exc_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  exc_pulse = '0;
   logic        clr_exc = 1'b0;
   logic        cw_load = 1'b0;
   logic [15:0] cw_data = '0;
   logic        busy_in = 1'b0;
   logic [3:0]  cc_in = '0;
   logic [2:0]  top_in = '0;
   logic [15:0] sw_out;
   logic [15:0] cw_out;
   logic        irq;
   logic [1:0]  round_ctl;
   logic [1:0]  prec_ctl;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   fpu_exc_status i_fpu_exc_status (
      .clk(clk), .rst_n(rst_n), .exc_pulse(exc_pulse), .clr_exc(clr_exc),
      .cw_load(cw_load), .cw_data(cw_data), .busy_in(busy_in), .cc_in(cc_in),
      .top_in(top_in), .sw_out(sw_out), .cw_out(cw_out), .irq(irq),
      .round_ctl(round_ctl), .prec_ctl(prec_ctl)
   );

   // [49:43] pulse, [42] clr, [41] load, [40:25] cw data,
   // [24:17] expected status[7:0], [16] expected irq, [15:0] expected cw
   localparam int NV = 10;
   localparam logic [49:0] VEC [NV] = '{
      {7'b0000001, 1'b0, 1'b0, 16'h0000, 8'h81, 1'b0, 16'h037F}, // R2 invalid, masked
      {7'b0000000, 1'b0, 1'b1, 16'h0C3E, 8'h81, 1'b1, 16'h0C3E}, // R3 R6 R7 unmask invalid
      {7'b0100000, 1'b0, 1'b0, 16'h0000, 8'hA1, 1'b1, 16'h0C3E}, // R2 precision
      {7'b0000000, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 16'h0C3E}, // R4 clear
      {7'b1000000, 1'b0, 1'b0, 16'h0000, 8'hC0, 1'b0, 16'h0C3E}, // R5 R6 stack fault only
      {7'b0000100, 1'b0, 1'b1, 16'h0000, 8'hC4, 1'b1, 16'h0000}, // R2 R7 zero-div + load
      {7'b0001000, 1'b1, 1'b0, 16'h0000, 8'h88, 1'b1, 16'h0000}, // R4 clear with overflow
      {7'b0000000, 1'b0, 1'b1, 16'h003F, 8'h88, 1'b0, 16'h003F}, // R10 re-mask
      {7'b0010010, 1'b0, 1'b0, 16'h0000, 8'h9A, 1'b0, 16'h003F}, // R2 underflow + denormal
      {7'b0000000, 1'b0, 1'b1, 16'h0FED, 8'h9A, 1'b1, 16'h0FED}  // R10 partial unmask
   };

   task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 cw after reset", cw_out, 16'h037F);
      check("R1 status after reset", sw_out, 16'h0000);
      check("R1 irq after reset", {15'd0, irq}, 16'd0);
      rst_n = 1'b1;
      check("R8 reset prec", {14'd0, prec_ctl}, 16'd3);
      check("R8 reset round", {14'd0, round_ctl}, 16'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         exc_pulse = VEC[i][49:43];
         clr_exc   = VEC[i][42];
         cw_load   = VEC[i][41];
         cw_data   = VEC[i][40:25];
         @(posedge clk);
         #1;
         exc_pulse = '0; clr_exc = 1'b0; cw_load = 1'b0; cw_data = '0;
         check($sformatf("R2/R3/R4/R5 flags vec %0d", i), {8'd0, sw_out[7:0]}, {8'd0, VEC[i][24:17]});
         check($sformatf("R6/R10 irq vec %0d", i), {15'd0, irq}, {15'd0, VEC[i][16]});
         check($sformatf("R7 cw vec %0d", i), cw_out, VEC[i][15:0]);
      end

      // R3 flags survive idle cycles
      repeat (4) @(posedge clk);
      #1;
      check("R3 flags after idle", {8'd0, sw_out[7:0]}, 16'h009A);

      // R8 mode fields follow the loaded word
      @(negedge clk);
      cw_load = 1'b1; cw_data = 16'h0A7F;
      @(negedge clk);
      cw_load = 1'b0;
      check("R8 round field", {14'd0, round_ctl}, 16'd2);
      check("R8 prec field", {14'd0, prec_ctl}, 16'd2);
      check("R10 mask all drops irq", {15'd0, irq}, 16'd0);

      // R9 live status bits
      busy_in = 1'b1; cc_in = 4'b1010; top_in = 3'b101;
      #1;
      check("R9 status high byte", {8'd0, sw_out[15:8]}, 16'h00EA);
      busy_in = 1'b0; cc_in = 4'b0101; top_in = 3'b010;
      #1;
      check("R9 status high byte alt", {8'd0, sw_out[15:8]}, 16'h0015);

      // R1 reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 cw on reset", cw_out, 16'h037F);
      check("R1 flags on reset", {8'd0, sw_out[7:0]}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;

      summary();
      $finish;
   end
endmodule